// File: doc/BRIEF.md
# DDR3 Nominal Termination State Tracker

This block is a clock-accurate model of the nominal on-die termination of a DDR3 memory device, seen from the device side. On every rising clock edge it registers the termination-enable input. It then replays that level after a synchronous latency equal to the CAS write latency plus the additive latency minus two. A three-bit nominal resistance selector gates the replayed level, and so does the self-refresh state. The outputs give the resulting termination state, the selected encoding and the RZQ divisor.

Next to the state model, the block checks the rules that a memory controller must keep. The enable input has a minimum high time after it rises and after a write that is issued while it is high. That time is longer for an eight-beat burst than for a chopped burst of four. Some resistance encodings are not allowed while a write is being terminated. Termination must be off when a read is issued. Each broken rule produces a one-cycle pulse on its own flag. The block can sit beside a controller in simulation, or be built into a device model.

Top module: `odt_term_tracker`

## Requirements
- R1: The selector `rtt_sel_i` decodes to the RZQ divisor as follows: 3'b001 gives 4, 3'b010 gives 2, 3'b011 gives 6, 3'b100 gives 12 and 3'b101 gives 8. While termination is on, `term_code_o` equals `rtt_sel_i` and `term_div_o` equals the divisor. While it is off, both outputs are zero.
- R2: The latency is L = `cwl_i` + `al_i` - 2 clocks. `term_on_o` follows the enable level that was registered L rising edges earlier. Termination therefore turns on L cycles after the enable is registered high and turns off L cycles after it is registered low.
- R3: When the selector is 3'b000 (disabled), 3'b110 or 3'b111 (reserved), `term_on_o` stays low whatever the enable level is.
- R4: While `self_ref_i` is high, `term_on_o` is low, whatever the enable history is.
- R5: `lat_err_o` is high whenever `cwl_i` + `al_i` - 2 is below 1 or above MAX_LAT. In that case the latency is clamped to 1 or to MAX_LAT.
- R6: When the enable is registered high after being registered low, it must then be registered high on the next 3 edges. If it is registered low within that window, `viol_hold_o` pulses for one cycle after that edge.
- R7: A write registered with the enable high extends the required high window: to 3 further edges for a chopped write (`cmd_type_i` = 2'b01) and to 5 further edges for an eight-beat write (2'b10). The longer of the running window and the new window is kept. A drop inside the window pulses `viol_hold_o`.
- R8: A write (2'b01 or 2'b10) registered with the enable high and a selector outside {3'b000, 3'b001, 3'b010, 3'b011} pulses `viol_wr_val_o` in the next cycle.
- R9: A read (`cmd_type_i` = 2'b00) registered while the enable is high or `term_on_o` is high pulses `viol_rd_o` in the next cycle. The code 2'b11 is a no-operation.
- R10: While reset is active and in the first cycle after it, `term_on_o`, `term_code_o`, `term_div_o` and all violation pulses are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| odt_i | input | 1 | Termination enable level |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_type_i | input | 2 | 00 read, 01 chopped write, 10 eight-beat write, 11 no-op |
| self_ref_i | input | 1 | Device is in self refresh |
| cwl_i | input | CWL_W | CAS write latency in clocks |
| al_i | input | AL_W | Additive latency in clocks |
| rtt_sel_i | input | 3 | Nominal resistance selector, mode bits 9,6,2 |
| term_on_o | output | 1 | Nominal termination applied |
| term_code_o | output | 3 | Active selector, zero when off |
| term_div_o | output | 4 | RZQ divisor in force, zero when off |
| lat_err_o | output | 1 | Latency out of the supported range |
| viol_hold_o | output | 1 | Minimum-high rule broken |
| viol_wr_val_o | output | 1 | Selector illegal during a write |
| viol_rd_o | output | 1 | Read issued with termination requested |

## Verification
The bench aims at the latency tap at its edges: L of 1, a clamped underflow and a clamped overflow. A design that is off by one stage would show termination one cycle early or late, and a design that does not clamp would read outside the pipeline. It drops the enable at every offset inside the 4-edge and 6-edge windows, including writes that arrive mid-window. A counter that reloads instead of keeping the longer window, or that mixes up the two burst lengths, would miss or invent hold pulses. Reserved and illegal-during-write selectors, self refresh and reads issued during the turn-off tail are all driven, so a design that ignored the pipelined state when checking reads would stay silent there.

// File: rtl/odt_pkg.sv
`timescale 1ns/1ps
package odt_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_WR4 = 2'b01,
    CMD_WR8 = 2'b10,
    CMD_NOP = 2'b11
  } odt_cmd_e;

  localparam int HOLD_SHORT = 4;
  localparam int HOLD_LONG  = 6;

  // RZQ divisor for a selector; zero for disabled or reserved codes
  function automatic logic [3:0] rtt_divisor(input logic [2:0] sel);
    logic [3:0] d;
    unique case (sel)
      3'b001:  d = 4'd4;
      3'b010:  d = 4'd2;
      3'b011:  d = 4'd6;
      3'b100:  d = 4'd12;
      3'b101:  d = 4'd8;
      default: d = 4'd0;
    endcase
    return d;
  endfunction

  function automatic logic rtt_active(input logic [2:0] sel);
    return (sel != 3'b000) && (sel <= 3'b101);
  endfunction

  // Selectors allowed while a write is terminated
  function automatic logic rtt_wr_legal(input logic [2:0] sel);
    return sel <= 3'b011;
  endfunction

  function automatic logic signed [9:0] calc_lat_raw(input logic [7:0] cwl,
                                                     input logic [7:0] al);
    return $signed({2'b00, cwl}) + $signed({2'b00, al}) - 10'sd2;
  endfunction

endpackage

// File: rtl/odt_lat_pipe.sv
`timescale 1ns/1ps
module odt_lat_pipe #(
  parameter int MAX_LAT = 20,
  parameter int LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             odt_i,
  input  logic [LAT_W-1:0] lat_sel_i,
  output logic             tap_o
);

  logic [MAX_LAT:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= odt_i;
  end

  for (genvar k = 1; k <= MAX_LAT; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= 1'b0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign tap_o = stage_q[lat_sel_i];

endmodule

// File: rtl/odt_hold_tracker.sv
`timescale 1ns/1ps
module odt_hold_tracker
  import odt_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       odt_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_type_i,
  output logic       busy_o,
  output logic       viol_o
);

  localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(HOLD_SHORT - 1);
  localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(HOLD_LONG - 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, dec, load;
  logic             viol_q;
  logic             rise_evt, wr_short_evt, wr_long_evt, drop_early;

  assign rise_evt     = odt_i & ~prev_q;
  assign wr_short_evt = cmd_valid_i & (cmd_type_i == CMD_WR4) & odt_i;
  assign wr_long_evt  = cmd_valid_i & (cmd_type_i == CMD_WR8) & odt_i;
  assign drop_early   = ~odt_i & (cnt_q != '0);

  always_comb begin
    dec  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    load = '0;
    if (rise_evt || wr_short_evt) load = LOAD_SHORT;
    if (wr_long_evt)              load = LOAD_LONG;
    if (!odt_i)            cnt_d = '0;
    else if (load > dec)   cnt_d = load;
    else                   cnt_d = dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      prev_q <= odt_i;
      cnt_q  <= cnt_d;
      viol_q <= drop_early;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign viol_o = viol_q;

endmodule

// File: rtl/odt_term_tracker.sv
`timescale 1ns/1ps
module odt_term_tracker
  import odt_pkg::*;
#(
  parameter int CWL_W   = 4,
  parameter int AL_W    = 4,
  parameter int MAX_LAT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             odt_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_type_i,
  input  logic             self_ref_i,
  input  logic [CWL_W-1:0] cwl_i,
  input  logic [AL_W-1:0]  al_i,
  input  logic [2:0]       rtt_sel_i,
  output logic             term_on_o,
  output logic [2:0]       term_code_o,
  output logic [3:0]       term_div_o,
  output logic             lat_err_o,
  output logic             viol_hold_o,
  output logic             viol_wr_val_o,
  output logic             viol_rd_o
);

  localparam int LAT_W = $clog2(MAX_LAT + 1);

  // named internal events, also seen by the checker
  logic signed [9:0] lat_raw;
  logic              lat_bad;
  logic [LAT_W-1:0]  lat_sel;
  logic              odt_tap;
  logic              hold_busy;
  logic              rd_evt;
  logic              wr_evt;
  logic              wr_bad_evt;
  logic              viol_wr_q, viol_rd_q;

  assign lat_raw = calc_lat_raw(8'(cwl_i), 8'(al_i));
  assign lat_bad = (lat_raw < 10'sd1) || (lat_raw > 10'(MAX_LAT));

  always_comb begin
    if (lat_raw < 10'sd1)               lat_sel = LAT_W'(1);
    else if (lat_raw > 10'(MAX_LAT))    lat_sel = LAT_W'(MAX_LAT);
    else                                lat_sel = lat_raw[LAT_W-1:0];
  end

  odt_lat_pipe #(
    .MAX_LAT (MAX_LAT),
    .LAT_W   (LAT_W)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .odt_i     (odt_i),
    .lat_sel_i (lat_sel),
    .tap_o     (odt_tap)
  );

  odt_hold_tracker #(
    .CNT_W (3)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .odt_i       (odt_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_type_i  (cmd_type_i),
    .busy_o      (hold_busy),
    .viol_o      (viol_hold_o)
  );

  assign term_on_o   = odt_tap & rtt_active(rtt_sel_i) & ~self_ref_i;
  assign term_code_o = term_on_o ? rtt_sel_i : 3'b000;
  assign term_div_o  = term_on_o ? rtt_divisor(rtt_sel_i) : 4'd0;
  assign lat_err_o   = lat_bad;

  assign rd_evt     = cmd_valid_i & (cmd_type_i == CMD_RD) & (odt_i | term_on_o);
  assign wr_evt     = cmd_valid_i & ((cmd_type_i == CMD_WR4) | (cmd_type_i == CMD_WR8));
  assign wr_bad_evt = wr_evt & odt_i & ~rtt_wr_legal(rtt_sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_wr_q <= 1'b0;
      viol_rd_q <= 1'b0;
    end else begin
      viol_wr_q <= wr_bad_evt;
      viol_rd_q <= rd_evt;
    end
  end

  assign viol_wr_val_o = viol_wr_q;
  assign viol_rd_o     = viol_rd_q;

endmodule

// File: rtl/odt_term_tracker_sva.sv
`timescale 1ns/1ps
module odt_term_tracker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       odt_i,
  input logic       cmd_valid_i,
  input logic [1:0] cmd_type_i,
  input logic       hold_busy,
  input logic       viol_hold_o,
  input logic       viol_wr_val_o,
  input logic       viol_rd_o
);

  // R6
  hold_busy_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |-> $past(odt_i));

  // R6
  hold_viol_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_hold_o |-> !$past(odt_i));

  // R7
  long_write_arms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_type_i == 2'b10 && odt_i) |=> hold_busy);

  // R8
  wr_viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_wr_val_o |-> ($past(cmd_valid_i) && $past(odt_i) &&
                       ($past(cmd_type_i) == 2'b01 || $past(cmd_type_i) == 2'b10)));

  // R9
  rd_viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_rd_o |-> ($past(cmd_valid_i) && $past(cmd_type_i) == 2'b00));

endmodule

bind odt_term_tracker odt_term_tracker_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .odt_i         (odt_i),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_type_i    (cmd_type_i),
  .hold_busy     (hold_busy),
  .viol_hold_o   (viol_hold_o),
  .viol_wr_val_o (viol_wr_val_o),
  .viol_rd_o     (viol_rd_o)
);

// File: tb/odt_term_tracker_tb.sv
`timescale 1ns/1ps
module odt_term_tracker_tb;

  localparam int MAXL = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       odt_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [1:0] cmd_type_i = 2'b11;
  logic       self_ref_i = 1'b0;
  logic [3:0] cwl_i = 4'd5;
  logic [3:0] al_i = 4'd0;
  logic [2:0] rtt_sel_i = 3'b001;
  logic       term_on_o, lat_err_o, viol_hold_o, viol_wr_val_o, viol_rd_o;
  logic [2:0] term_code_o;
  logic [3:0] term_div_o;

  odt_term_tracker #(.CWL_W(4), .AL_W(4), .MAX_LAT(MAXL)) u_dut (
    .clk(clk), .rst_n(rst_n), .odt_i(odt_i), .cmd_valid_i(cmd_valid_i),
    .cmd_type_i(cmd_type_i), .self_ref_i(self_ref_i), .cwl_i(cwl_i), .al_i(al_i),
    .rtt_sel_i(rtt_sel_i), .term_on_o(term_on_o), .term_code_o(term_code_o),
    .term_div_o(term_div_o), .lat_err_o(lat_err_o), .viol_hold_o(viol_hold_o),
    .viol_wr_val_o(viol_wr_val_o), .viol_rd_o(viol_rd_o));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit hist[$];
  bit m_prev;
  int m_req_until;
  int m_cyc;
  bit m_vh, m_vw, m_vr;

  function automatic int div_of(input int s);
    case (s)
      1: return 4; 2: return 2; 3: return 6; 4: return 12; 5: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int eff_lat();
    int l = int'(cwl_i) + int'(al_i) - 2;
    if (l < 1) l = 1;
    if (l > MAXL) l = MAXL;
    return l;
  endfunction

  function automatic bit exp_term();
    int l = eff_lat();
    bit lvl = (hist.size() > l) ? hist[l] : 1'b0;
    return lvl && rtt_sel_i >= 1 && rtt_sel_i <= 5 && !self_ref_i;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, m_cyc);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i <= MAXL; i++) hist.push_back(1'b0);
    m_prev = 0; m_req_until = -1; m_cyc = 0;
    m_vh = 0; m_vw = 0; m_vr = 0;
  endtask

  task automatic compare_all();
    bit t = exp_term();
    int raw = int'(cwl_i) + int'(al_i) - 2;
    chk("R2", "term_on", term_on_o, t);
    chk("R1", "term_code", term_code_o, t ? int'(rtt_sel_i) : 0);
    chk("R1", "term_div", term_div_o, t ? div_of(rtt_sel_i) : 0);
    chk("R5", "lat_err", lat_err_o, (raw < 1 || raw > MAXL) ? 1 : 0);
    chk("R6", "viol_hold", viol_hold_o, m_vh);
    chk("R8", "viol_wr_val", viol_wr_val_o, m_vw);
    chk("R9", "viol_rd", viol_rd_o, m_vr);
    if (rtt_sel_i == 0 || rtt_sel_i >= 6) chk("R3", "term_off_code", term_on_o, 0);
    if (self_ref_i) chk("R4", "term_off_sr", term_on_o, 0);
  endtask

  // one cycle: compare at settle, then advance model over the edge
  task automatic step();
    bit t, rd_hit, wr, wr_bad, wr4, wr8, rise;
    #1;
    compare_all();
    t = exp_term();
    rd_hit = cmd_valid_i && cmd_type_i == 2'b00 && (odt_i || t);
    wr4 = cmd_valid_i && cmd_type_i == 2'b01;
    wr8 = cmd_valid_i && cmd_type_i == 2'b10;
    wr = wr4 || wr8;
    wr_bad = wr && odt_i && rtt_sel_i > 3;
    @(posedge clk);
    hist.push_front(odt_i);
    void'(hist.pop_back());
    m_vr = rd_hit;
    m_vw = wr_bad;
    m_vh = 0;
    if (!odt_i) begin
      if (m_cyc <= m_req_until) m_vh = 1;
      m_req_until = -1;
    end else begin
      rise = !m_prev;
      // R6 window after a rise, R7 windows after writes
      if ((rise || wr4) && m_req_until < m_cyc + 3) m_req_until = m_cyc + 3;
      if (wr8 && m_req_until < m_cyc + 5) m_req_until = m_cyc + 5;
    end
    m_prev = odt_i;
    m_cyc++;
    @(negedge clk);
  endtask

  task automatic set_lat(input int c, input int a);
    odt_i = 0; cmd_valid_i = 0;
    repeat (MAXL + 3) step();
    cwl_i = 4'(c); al_i = 4'(a);
    repeat (2) step();
  endtask

  // R6: drop after a rise at offset k (1..4)
  task automatic pulse(input int len);
    odt_i = 1; repeat (len) step();
    odt_i = 0; repeat (3) step();
  endtask

  task automatic random_run(input int n);
    int run = 0;
    for (int i = 0; i < n; i++) begin
      if (run == 0) begin
        odt_i = ~odt_i;
        run = 1 + ($urandom % 9);
      end
      run--;
      cmd_valid_i = ($urandom % 3) == 0;
      cmd_type_i = 2'($urandom % 4);
      if (($urandom % 8) == 0) rtt_sel_i = 3'($urandom % 8);
      self_ref_i = ($urandom % 16) == 0;
      step();
    end
    odt_i = 0; cmd_valid_i = 0; self_ref_i = 0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "term_on_rst", term_on_o, 0);
    chk("R10", "viol_rst", {viol_hold_o, viol_wr_val_o, viol_rd_o}, 0);
    chk("R10", "code_rst", term_code_o, 0);
    rst_n = 1;
    step();

    // R2: directed latency 3, selector RZQ/2
    rtt_sel_i = 3'b010;
    odt_i = 1; repeat (6) step();
    odt_i = 0; repeat (6) step();
    // R6: early drops at every offset
    for (int k = 1; k <= 4; k++) pulse(k);
    // R7: chopped and long writes mid-window
    odt_i = 1; step();
    cmd_valid_i = 1; cmd_type_i = 2'b10; step();
    cmd_valid_i = 0; repeat (3) step();
    odt_i = 0; repeat (3) step();
    odt_i = 1; repeat (2) step();
    cmd_valid_i = 1; cmd_type_i = 2'b01; step();
    cmd_valid_i = 0; step(); step();
    odt_i = 0; repeat (3) step();
    // R8: illegal selector during write
    rtt_sel_i = 3'b100; odt_i = 1;
    cmd_valid_i = 1; cmd_type_i = 2'b01; step();
    cmd_valid_i = 0; repeat (6) step();
    // R9: read during turn-off tail
    odt_i = 0; step();
    cmd_valid_i = 1; cmd_type_i = 2'b00; step();
    cmd_valid_i = 0; repeat (4) step();
    // R3 and R4
    rtt_sel_i = 3'b110; odt_i = 1; repeat (6) step();
    rtt_sel_i = 3'b000; repeat (2) step();
    rtt_sel_i = 3'b011; self_ref_i = 1; repeat (2) step();
    self_ref_i = 0; odt_i = 0; repeat (6) step();

    // R5 and R2 across latencies, including clamps
    set_lat(3, 0); random_run(300);
    set_lat(6, 4); random_run(300);
    set_lat(2, 0); random_run(300);
    set_lat(15, 15); random_run(300);
    set_lat(9, 3); random_run(300);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule